// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Controller

This block is the digital control core of a center-spread clock modulator. It runs in the reference clock domain and steps a periodic frequency-modulation profile. Each cycle it emits a signed frequency-offset word in units of 0.01 %. Fractional-divider logic outside the block would apply that word to the synthesized clock. The sweep goes from the lowest frequency up to the highest and back again. It is centered on the nominal frequency, so the offset swings equally above and below zero.

Two decoded three-level select codes and a reference-band index choose one of nine peak-to-peak spread settings. Five settings belong to the low reference range (54 to 108 MHz) and four to the high range (108 to 166 MHz). A spread enable turns the modulation on or off. All configuration inputs are captured only at the boundary between periods, so the offset never jumps in the middle of a sweep. The block also emits a strobe at the start of each period and reports the peak-to-peak spread that is currently active.

Top module: `sscg_profile_ctrl`

## Requirements
- R1: `period_start` is high for exactly one cycle per modulation period. Consecutive strobes are exactly 2332 cycles apart, whatever the configuration.
- R2: Let `pp` be the active peak-to-peak spread. The offset stays within ±`pp`/2. It equals −`pp`/2 in the strobe cycle (phase 0) and at phase 2331, and +`pp`/2 at phases 1165 and 1166.
- R3: The profile is symmetric in time about its peak: the offset at phase k equals the offset at phase 2331−k.
- R4: The shape is piecewise linear and never falls during the up-sweep (phases 0..1165). The offset moves by at most one unit between adjacent cycles of a period. Its rise over the first 100 phases is larger than its rise over phases 533..633.
- R5: When the enable was low at the period boundary, the offset and `peak_pp` are zero for the whole period, and the strobe keeps its 2332-cycle rhythm.
- R6: Select codes are encoded 00 = low, 01 = middle, 10 = high. Band index 0..4 means 54-60, 60-70, 70-80, 80-100 and 100-108 MHz. In those bands, `peak_pp` (0.01 % units) is: (middle,middle) 360/350/330/300/260; (middle,low) 310/300/280/250/230; (high,low) 260/250/240/210/190; (low,low) 210/200/190/170/150; (low,middle) 180/170/160/140/130. The pair is written (`sel_a`,`sel_b`).
- R7: Band index 5..9 means 108-120, 120-130, 130-140, 140-150 and 150-166 MHz. In those bands, `peak_pp` is: (high,middle) 230/230/230/220/210; (low,high) 170/170/170/160/150; (high,high) 110/110/110/110/100; (middle,high) 90/90/90/90/80.
- R8: Code 11 on either select forces the offset and `peak_pp` to zero for that period.
- R9: A select pair that has no entry in the current band, or a band index of 10 or more, forces the offset and `peak_pp` to zero for that period.
- R10: Changes on the selects, the band or the enable have no effect until the next `period_start`. A change made during a period takes effect from the following strobe onward.
- R11: While reset is high, the offset, `peak_pp` and `period_start` are zero. The first strobe arrives on the second rising edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_a | input | 2 | First three-level spread select (00 low, 01 middle, 10 high) |
| sel_b | input | 2 | Second three-level spread select (same encoding) |
| band | input | BAND_W | Reference frequency band index (0..9) |
| spread_en | input | 1 | Modulation enable; tie high by default |
| offset | output | OFF_W | Signed frequency offset, 0.01 % units |
| period_start | output | 1 | One-cycle strobe marking phase 0 of a period |
| peak_pp | output | PP_W | Active peak-to-peak spread, 0.01 % units |

## Verification
The assertions assume that the configuration inputs reach the output only at a strobe. They also assume that no active spread exceeds what a one-unit-per-cycle slew can follow, which holds for every setting in the table. The bench keeps to this: it changes inputs only on falling edges and waits for a strobe before it judges a new setting. Each setting is observed over one whole period, and the mid-period change is made well away from the boundary edge. Out-of-band and illegal codes are driven as ordinary stimulus, because the block must treat them as zero spread and not as undefined input.

// File: rtl/sscg_pkg.sv
package sscg_pkg;

    localparam int PP_W = 9;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'b00,
        LVL_MID  = 2'b01,
        LVL_HIGH = 2'b10,
        LVL_BAD  = 2'b11
    } lvl_e;

    typedef struct packed {
        logic [PP_W-1:0] pp;
    } spread_cfg_t;

    function automatic logic [PP_W-1:0] pick5(input int idx, input int v0, input int v1,
                                              input int v2, input int v3, input int v4);
        int r;
        case (idx)
            0:       r = v0;
            1:       r = v1;
            2:       r = v2;
            3:       r = v3;
            4:       r = v4;
            default: r = 0;
        endcase
        return PP_W'(r);
    endfunction

    function automatic logic [PP_W-1:0] spread_lookup(input lvl_e a, input lvl_e b, input int bnd);
        logic [PP_W-1:0] r;
        r = '0;
        if (bnd >= 0 && bnd < 5) begin
            case ({a, b})
                {LVL_MID,  LVL_MID}:  r = pick5(bnd, 360, 350, 330, 300, 260);
                {LVL_MID,  LVL_LOW}:  r = pick5(bnd, 310, 300, 280, 250, 230);
                {LVL_HIGH, LVL_LOW}:  r = pick5(bnd, 260, 250, 240, 210, 190);
                {LVL_LOW,  LVL_LOW}:  r = pick5(bnd, 210, 200, 190, 170, 150);
                {LVL_LOW,  LVL_MID}:  r = pick5(bnd, 180, 170, 160, 140, 130);
                default:              r = '0;
            endcase
        end else if (bnd >= 5 && bnd < 10) begin
            case ({a, b})
                {LVL_HIGH, LVL_MID}:  r = pick5(bnd - 5, 230, 230, 230, 220, 210);
                {LVL_LOW,  LVL_HIGH}: r = pick5(bnd - 5, 170, 170, 170, 160, 150);
                {LVL_HIGH, LVL_HIGH}: r = pick5(bnd - 5, 110, 110, 110, 110, 100);
                {LVL_MID,  LVL_HIGH}: r = pick5(bnd - 5,  90,  90,  90,  90,  80);
                default:              r = '0;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/sscg_phase_gen.sv
module sscg_phase_gen #(
    parameter int PERIOD = 2332,
    localparam int CNT_W = $clog2(PERIOD)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] phase,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    // Reset parks the counter on the last phase so the first edge out of
    // reset is a period boundary that captures the configuration.
    always_ff @(posedge clk) begin
        if (rst)       phase <= LAST;
        else if (wrap) phase <= '0;
        else           phase <= phase + 1'b1;
    end

    assign wrap = (phase == LAST);
endmodule

// File: rtl/sscg_cfg_latch.sv
module sscg_cfg_latch
    import sscg_pkg::*;
#(
    parameter int BAND_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [1:0]        sel_a,
    input  logic [1:0]        sel_b,
    input  logic [BAND_W-1:0] band,
    input  logic              spread_en,
    output spread_cfg_t       cfg
);
    spread_cfg_t next_cfg;

    always_comb begin
        next_cfg.pp = '0;
        if (spread_en)
            next_cfg.pp = spread_lookup(lvl_e'(sel_a), lvl_e'(sel_b), int'(band));
    end

    always_ff @(posedge clk) begin
        if (rst)       cfg <= '0;
        else if (load) cfg <= next_cfg;
    end
endmodule

// File: rtl/sscg_shape.sv
module sscg_shape
    import sscg_pkg::*;
#(
    parameter int PERIOD = 2332,
    parameter int OFF_W  = 10,
    localparam int CNT_W  = $clog2(PERIOD),
    localparam int HALF   = PERIOD / 2,
    localparam int P_LAST = HALF - 1,
    localparam int EDGE   = P_LAST / 4,
    localparam int S_MAX  = P_LAST + 2 * EDGE,
    localparam int S_W    = $clog2(S_MAX + 1),
    localparam int PROD_W = PP_W + S_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [CNT_W-1:0]        phase,
    input  spread_cfg_t             cfg,
    output logic signed [OFF_W-1:0] offset,
    output logic                    start,
    output logic [PP_W-1:0]         peak
);
    localparam logic [CNT_W-1:0]  HALF_C  = CNT_W'(HALF);
    localparam logic [CNT_W-1:0]  MIRROR  = CNT_W'(PERIOD - 1);
    localparam logic [CNT_W-1:0]  EDGE_C  = CNT_W'(EDGE);
    localparam logic [CNT_W-1:0]  KNEE_C  = CNT_W'(P_LAST - EDGE);
    localparam logic [S_W-1:0]    EDGE_S  = S_W'(EDGE);
    localparam logic [S_W-1:0]    PLAST_S = S_W'(P_LAST);
    localparam logic [PROD_W-1:0] S_DIV   = PROD_W'(S_MAX);

    logic [CNT_W-1:0]        fold;
    logic [S_W-1:0]          shaped;
    logic [PROD_W-1:0]       prod;
    logic [OFF_W-1:0]        quot;
    logic signed [OFF_W-1:0] off_n;

    always_comb begin
        // Fold the phase so both halves read the same ramp position.
        fold = (phase < HALF_C) ? phase : (MIRROR - phase);
        // Slope two in the outer quarters, slope one through the middle.
        if (fold < EDGE_C)
            shaped = S_W'(fold) << 1;
        else if (fold <= KNEE_C)
            shaped = S_W'(fold) + EDGE_S;
        else
            shaped = PLAST_S + (S_W'(fold - KNEE_C) << 1);
        prod  = PROD_W'(cfg.pp) * PROD_W'(shaped);
        quot  = OFF_W'(prod / S_DIV);
        off_n = $signed(quot) - $signed(OFF_W'(cfg.pp >> 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            offset <= '0;
            start  <= 1'b0;
            peak   <= '0;
        end else begin
            offset <= off_n;
            start  <= (phase == '0);
            peak   <= cfg.pp;
        end
    end
endmodule

// File: rtl/sscg_profile_ctrl.sv
module sscg_profile_ctrl
    import sscg_pkg::*;
#(
    parameter int PERIOD = 2332,
    parameter int BAND_W = 4,
    parameter int OFF_W  = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [1:0]              sel_a,
    input  logic [1:0]              sel_b,
    input  logic [BAND_W-1:0]       band,
    input  logic                    spread_en,
    output logic signed [OFF_W-1:0] offset,
    output logic                    period_start,
    output logic [PP_W-1:0]         peak_pp
);
    localparam int CNT_W = $clog2(PERIOD);

    logic [CNT_W-1:0] phase;
    logic             wrap;
    spread_cfg_t      cfg;

    sscg_phase_gen #(.PERIOD(PERIOD)) u_phase (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .wrap  (wrap)
    );

    sscg_cfg_latch #(.BAND_W(BAND_W)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .load      (wrap),
        .sel_a     (sel_a),
        .sel_b     (sel_b),
        .band      (band),
        .spread_en (spread_en),
        .cfg       (cfg)
    );

    sscg_shape #(.PERIOD(PERIOD), .OFF_W(OFF_W)) u_shape (
        .clk    (clk),
        .rst    (rst),
        .phase  (phase),
        .cfg    (cfg),
        .offset (offset),
        .start  (period_start),
        .peak   (peak_pp)
    );
endmodule

// File: rtl/sscg_profile_chk.sv
module sscg_profile_chk
    import sscg_pkg::*;
#(
    parameter int PERIOD = 2332,
    parameter int OFF_W  = 10
) (
    input logic                    clk,
    input logic                    rst,
    input logic signed [OFF_W-1:0] offset,
    input logic                    period_start,
    input logic [PP_W-1:0]         peak_pp
);
    localparam int GAP_W = $clog2(PERIOD) + 1;
    localparam logic [GAP_W-1:0] GAP_END = GAP_W'(PERIOD - 1);

    logic [GAP_W-1:0]        gap;
    logic                    seen;
    logic signed [OFF_W-1:0] prev_off;
    logic signed [OFF_W-1:0] half_s;
    logic signed [OFF_W:0]   step;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap      <= '0;
            seen     <= 1'b0;
            prev_off <= '0;
        end else begin
            prev_off <= offset;
            if (period_start) begin
                gap  <= '0;
                seen <= 1'b1;
            end else if (gap != '1) begin
                gap <= gap + 1'b1;
            end
        end
    end

    assign half_s = $signed(OFF_W'(peak_pp >> 1));
    assign step   = (OFF_W+1)'(offset) - (OFF_W+1)'(prev_off);

    // R1: strobes exactly one period apart
    a_r1_period_gap: assert property (@(posedge clk) disable iff (rst)
        (period_start && seen) |-> (gap == GAP_END));

    // R1: strobe lasts one cycle
    a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
        period_start |=> !period_start);

    // R2: offset bounded by half the active spread
    a_r2_bounded: assert property (@(posedge clk) disable iff (rst)
        (offset <= half_s) && (offset >= -half_s));

    // R2: each period starts at the minimum
    a_r2_start_min: assert property (@(posedge clk) disable iff (rst)
        period_start |-> (offset == -half_s));

    // R4: one unit per cycle at most inside a period
    a_r4_slew: assert property (@(posedge clk) disable iff (rst)
        !period_start |-> (step <= 1 && step >= -1));

    // R5: zero spread means zero offset
    a_r5_zero_when_idle: assert property (@(posedge clk) disable iff (rst)
        (peak_pp == '0) |-> (offset == '0));

    // R10: configuration only changes at a period boundary
    a_r10_peak_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(peak_pp) |-> period_start);
endmodule

bind sscg_profile_ctrl sscg_profile_chk #(.PERIOD(PERIOD), .OFF_W(OFF_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .offset       (offset),
    .period_start (period_start),
    .peak_pp      (peak_pp)
);

// File: tb/sscg_profile_ctrl_test.sv
module sscg_profile_ctrl_test;
    localparam int PERIOD = 2332;
    localparam int HALF   = PERIOD / 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        sel_a = 2'b01;
    logic [1:0]        sel_b = 2'b01;
    logic [3:0]        band = 4'd1;
    logic              spread_en = 1'b1;
    logic signed [9:0] offset;
    logic              period_start;
    logic [8:0]        peak_pp;

    int checks = 0;
    int errors = 0;
    int arr [PERIOD];

    always #4 clk = ~clk;

    sscg_profile_ctrl uut (
        .clk          (clk),
        .rst          (rst),
        .sel_a        (sel_a),
        .sel_b        (sel_b),
        .band         (band),
        .spread_en    (spread_en),
        .offset       (offset),
        .period_start (period_start),
        .peak_pp      (peak_pp)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic wait_strobe(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!period_start && n < PERIOD + 8);
    endtask

    task automatic apply(input logic [1:0] a, input logic [1:0] b, input int bnd, input logic en);
        int n;
        sel_a = a; sel_b = b; band = 4'(bnd); spread_en = en;
        wait_strobe(n);
    endtask

    // Called at a strobe negedge; observes a whole period and ends at the next strobe.
    task automatic record_period(input int pp_exp, input string tag);
        int bad_peak = 0, extra_strobe = 0, asym = 0, drops = 0;
        int mx = -1000, mn = 1000, a_half;
        a_half = pp_exp / 2;
        for (int k = 0; k < PERIOD; k++) begin
            if (k != 0) @(negedge clk);
            arr[k] = int'(offset);
            if (int'(peak_pp) != pp_exp) bad_peak++;
            if (k != 0 && period_start) extra_strobe++;
            if (arr[k] > mx) mx = arr[k];
            if (arr[k] < mn) mn = arr[k];
        end
        @(negedge clk);
        chk(period_start == 1'b1 && extra_strobe == 0,
            $sformatf("R1 %s strobe spacing (extra strobes)", tag), extra_strobe, 0);
        chk(bad_peak == 0, $sformatf("%s peak_pp value", tag), bad_peak == 0 ? pp_exp : int'(peak_pp), pp_exp);
        chk(arr[0] == -a_half && arr[PERIOD-1] == -a_half, $sformatf("R2 %s start/end minimum", tag), arr[0], -a_half);
        chk(arr[HALF-1] == a_half && arr[HALF] == a_half, $sformatf("R2 %s peak at midpoint", tag), arr[HALF-1], a_half);
        chk(mx == a_half && mn == -a_half, $sformatf("R2 %s max/min", tag), mx, a_half);
        for (int k = 0; k < HALF; k++) if (arr[k] != arr[PERIOD-1-k]) asym++;
        chk(asym == 0, $sformatf("R3 %s symmetry mismatches", tag), asym, 0);
        for (int k = 1; k < HALF; k++) if (arr[k] < arr[k-1]) drops++;
        chk(drops == 0, $sformatf("R4 %s up-sweep monotone", tag), drops, 0);
        if (pp_exp >= 50)
            chk((arr[100] - arr[0]) > (arr[633] - arr[533]),
                $sformatf("R4 %s edge slew exceeds middle slew", tag), arr[100] - arr[0], arr[633] - arr[533]);
    endtask

    task automatic t_reset;
        int n;
        chk(offset == 0 && peak_pp == 0 && period_start == 1'b0, "R11 reset outputs zero",
            int'(offset) + int'(peak_pp) + int'(period_start), 0);
        @(negedge clk);
        rst = 1'b0;
        wait_strobe(n);
        chk(n == 2, "R11 first strobe on second edge after reset", n, 2);
        record_period(350, "R6 (mid,mid) band1");
    endtask

    task automatic t_profile(input logic [1:0] a, input logic [1:0] b, input int bnd, input int pp, input string tag);
        apply(a, b, bnd, 1'b1);
        record_period(pp, tag);
    endtask

    task automatic t_disable;
        apply(2'b01, 2'b01, 1, 1'b0);
        record_period(0, "R5 disabled");
        apply(2'b01, 2'b01, 1, 1'b1);
        record_period(350, "R5 re-enabled");
    endtask

    task automatic t_mid_change;
        int bad = 0;
        apply(2'b01, 2'b01, 1, 1'b1);
        for (int k = 1; k < PERIOD; k++) begin
            @(negedge clk);
            if (k == 1000) begin
                sel_a = 2'b00; sel_b = 2'b00; band = 4'd2;
            end
            if (peak_pp != 9'd350) bad++;
            if (k == HALF - 1)
                chk(offset == 175, "R10 peak unchanged after mid-period change", int'(offset), 175);
        end
        chk(bad == 0, "R10 peak_pp held until boundary", bad, 0);
        @(negedge clk);
        chk(period_start == 1'b1 && peak_pp == 9'd190, "R10 new setting at next strobe", int'(peak_pp), 190);
        chk(offset == -95, "R10 new minimum at next strobe", int'(offset), -95);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_profile(2'b01, 2'b00, 0, 310, "R6 (mid,low) band0");
        t_profile(2'b10, 2'b00, 4, 190, "R6 (high,low) band4");
        t_profile(2'b00, 2'b00, 2, 190, "R6 (low,low) band2");
        t_profile(2'b00, 2'b01, 3, 140, "R6 (low,mid) band3");
        t_profile(2'b10, 2'b01, 9, 210, "R7 (high,mid) band9");
        t_profile(2'b00, 2'b10, 5, 170, "R7 (low,high) band5");
        t_profile(2'b10, 2'b10, 8, 110, "R7 (high,high) band8");
        t_profile(2'b01, 2'b10, 9, 80,  "R7 (mid,high) band9");
        t_profile(2'b11, 2'b00, 1, 0,   "R8 illegal first select");
        t_profile(2'b01, 2'b11, 6, 0,   "R8 illegal second select");
        t_profile(2'b10, 2'b01, 2, 0,   "R9 high-range pair in low band");
        t_profile(2'b01, 2'b01, 7, 0,   "R9 low-range pair in high band");
        t_profile(2'b01, 2'b01, 12, 0,  "R9 band index out of range");
        t_disable();
        t_mid_change();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule